// File: doc/BRIEF.md
# Instruction Fetch Address Generator with Hardware Return Stack

This block produces the program-space fetch address for a small 8-bit core whose program store is separate from its data store. It holds a 21-bit byte address. Every instruction word is 16 bits wide, so the address is always even. Each clock cycle the address can do one of the following: hold, step to the next instruction, load a branch target, enter a subroutine, return from one, or jump to one of two fixed interrupt entry points. A cleared reset puts the address at zero.

Return addresses are kept in a dedicated 31-level register stack. This stack is separate from both program and data memory. Its fill count and its top entry are visible at the ports. A call or an accepted interrupt pushes the address of the following instruction. A return pops the top entry into the fetch address. Pushing onto a full stack and popping an empty one are both reported through flags that stay set until reset.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Each strobe is sampled on the rising clock edge, and its effect is visible on the outputs right after that edge.

Top module: `fetch_pc_unit`

## Requirements
- R1: The fetch address is 21 bits wide and its bit 0 is always 0. Bit 0 of a loaded target is ignored.
- R2: While reset is asserted (rst_n low), the fetch address is 000000h, the stack count is 0, the top-of-stack output is 0, and both flags are 0.
- R3: With only `adv` high, the fetch address increases by 2 at the next edge, wrapping from 1FFFFEh to 000000h. With no strobe high, the address holds.
- R4: `jmp` loads the target into the fetch address and leaves the stack count and top of stack unchanged.
- R5: `call` pushes the current address plus 2, increments the stack count, and loads the target. The pushed value then appears on `tos`.
- R6: `ret` loads the top entry into the fetch address and decrements the stack count. Entries come back in last-in, first-out order.
- R7: `irq_hi` pushes the current address plus 2 and redirects fetch to 000008h.
- R8: `irq_lo` pushes the current address plus 2 and redirects fetch to 000018h. When `irq_hi` and `irq_lo` are high together, fetch goes to 000008h and exactly one entry is pushed.
- R9: When several strobes are high in one cycle, only one takes effect. The order is `irq_hi`, then `irq_lo`, `ret`, `call`, `jmp`, and last `adv`.
- R10: A push with 31 entries held sets `ovf`. The count stays 31, the top entry is unchanged, and the fetch address still moves to the call or vector target.
- R11: A pop with the stack empty sets `unf`, loads 000000h into the fetch address, and leaves the count at 0.
- R12: `ovf` and `unf` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Step to next instruction |
| jmp | input | 1 | Load target address |
| call | input | 1 | Push return address and load target |
| ret | input | 1 | Pop return address into fetch address |
| irq_hi | input | 1 | High-priority interrupt accepted |
| irq_lo | input | 1 | Low-priority interrupt accepted |
| tgt | input | 21 | Branch or call target byte address |
| fetch_addr | output | 21 | Current program fetch address |
| sp | output | 5 | Number of entries held on the return stack |
| tos | output | 21 | Top stack entry, 0 when empty |
| ovf | output | 1 | Sticky stack overflow flag |
| unf | output | 1 | Sticky stack underflow flag |

## Verification
The bench fills all 31 levels and then issues one more call. A design with an off-by-one full test would either overwrite the top entry or corrupt the count, and the following return sequence would come back in the wrong order. The bench pops an empty stack to check that the address goes to zero rather than to a stale entry. It also checks that `ovf` survives later pops. It raises both interrupt requests together and stacks several strobes in one cycle, so a wrong priority order shows up as the wrong vector or as a double push. It loads an odd target and steps across the top of the address space to expose bit-0 leakage and a wrong wrap.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_SEQ,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET,
    ACT_VEC_HI,
    ACT_VEC_LO
  } fpc_act_e;
endpackage

// File: rtl/fpc_arbiter.sv
module fpc_arbiter
  import fpc_pkg::*;
(
  input  logic     adv,
  input  logic     jmp,
  input  logic     call,
  input  logic     ret,
  input  logic     irq_hi,
  input  logic     irq_lo,
  output fpc_act_e act,
  output logic     push,
  output logic     pop
);
  // Fixed priority: high vector, low vector, return, call, jump, step (R9)
  always_comb begin
    act = ACT_HOLD;
    if (irq_hi)      act = ACT_VEC_HI;
    else if (irq_lo) act = ACT_VEC_LO;
    else if (ret)    act = ACT_RET;
    else if (call)   act = ACT_CALL;
    else if (jmp)    act = ACT_JUMP;
    else if (adv)    act = ACT_SEQ;
  end

  assign push = (act == ACT_CALL) || (act == ACT_VEC_HI) || (act == ACT_VEC_LO);
  assign pop  = (act == ACT_RET);
endmodule

// File: rtl/fpc_retstack.sv
module fpc_retstack #(
  parameter int AW    = 21,
  parameter int DEPTH = 31,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [AW-1:0]  push_val,
  output logic [AW-1:0]  tos,
  output logic [SPW-1:0] sp,
  output logic           ovf,
  output logic           unf
);
  localparam logic [SPW-1:0] FULL_CNT = SPW'(DEPTH);

  logic [AW-1:0]  mem [DEPTH];
  logic           full, empty;
  logic [SPW-1:0] sp_m1;
  logic [IW-1:0]  top_idx;

  assign full    = (sp == FULL_CNT);
  assign empty   = (sp == '0);
  assign sp_m1   = sp - 1'b1;
  assign top_idx = sp_m1[IW-1:0];

  // One register per level; a level is written only when it is the next free slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem[i] <= '0;
      else if (push && !full && sp == SPW'(i))      mem[i] <= push_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push) begin
        if (full) ovf <= 1'b1;
        else      sp  <= sp + 1'b1;
      end else if (pop) begin
        if (empty) unf <= 1'b1;
        else       sp  <= sp_m1;
      end
    end
  end

  assign tos = empty ? '0 : mem[top_idx];

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= FULL_CNT); // R10
  AST_OVF_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |=> ovf && sp == FULL_CNT && $stable(tos)); // R10
  AST_UNF_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty |=> unf && sp == '0); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R12
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf); // R12
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full |=> tos == $past(push_val)); // R5
endmodule

// File: rtl/fpc_pcreg.sv
module fpc_pcreg
  import fpc_pkg::*;
#(
  parameter int            AW     = 21,
  parameter logic [AW-1:0] VEC_HI = AW'(8),
  parameter logic [AW-1:0] VEC_LO = AW'(24)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fpc_act_e      act,
  input  logic [AW-1:0] tgt,
  input  logic [AW-1:0] pop_val,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_next_seq
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] tgt_even;
  logic [AW-1:0] pc_d;

  assign pc_next_seq = pc + STEP;
  assign tgt_even    = {tgt[AW-1:1], 1'b0};

  always_comb begin
    unique case (act)
      ACT_SEQ:    pc_d = pc_next_seq;
      ACT_JUMP,
      ACT_CALL:   pc_d = tgt_even;
      ACT_RET:    pc_d = {pop_val[AW-1:1], 1'b0};
      ACT_VEC_HI: pc_d = VEC_HI;
      ACT_VEC_LO: pc_d = VEC_LO;
      default:    pc_d = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_d;
  end

  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pc[0] == 1'b0); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_SEQ |=> pc == AW'($past(pc) + STEP)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_HOLD |=> $stable(pc)); // R3
  AST_VEC_HI: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_VEC_HI |=> pc == VEC_HI); // R7
  AST_VEC_LO: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_VEC_LO |=> pc == VEC_LO); // R8
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fpc_pkg::*;
#(
  parameter int            AW     = 21,
  parameter int            DEPTH  = 31,
  parameter logic [AW-1:0] VEC_HI = AW'(8),
  parameter logic [AW-1:0] VEC_LO = AW'(24),
  localparam int           SPW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           jmp,
  input  logic           call,
  input  logic           ret,
  input  logic           irq_hi,
  input  logic           irq_lo,
  input  logic [AW-1:0]  tgt,
  output logic [AW-1:0]  fetch_addr,
  output logic [SPW-1:0] sp,
  output logic [AW-1:0]  tos,
  output logic           ovf,
  output logic           unf
);
  fpc_act_e      act;
  logic          push, pop;
  logic [AW-1:0] ret_addr;

  fpc_arbiter u_arb (
    .adv(adv), .jmp(jmp), .call(call), .ret(ret),
    .irq_hi(irq_hi), .irq_lo(irq_lo),
    .act(act), .push(push), .pop(pop)
  );

  fpc_retstack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_val(ret_addr), .tos(tos), .sp(sp), .ovf(ovf), .unf(unf)
  );

  fpc_pcreg #(.AW(AW), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_pc (
    .clk(clk), .rst_n(rst_n), .act(act), .tgt(tgt), .pop_val(tos),
    .pc(fetch_addr), .pc_next_seq(ret_addr)
  );

  AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi && irq_lo |=> fetch_addr == VEC_HI); // R8
  AST_RET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !irq_hi && !irq_lo && $past(sp) != '0 |=> fetch_addr == $past(tos)); // R9
  AST_JUMP_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    jmp && !call && !ret && !irq_hi && !irq_lo |=> $stable(sp)); // R4
endmodule

// File: tb/tb_fetch_pc_unit.sv
`timescale 1ns/1ps
module tb_fetch_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 0, jmp = 0, call = 0, ret = 0, irq_hi = 0, irq_lo = 0;
  logic [20:0] tgt = '0;
  logic [20:0] fetch_addr, tos;
  logic [4:0]  sp;
  logic        ovf, unf;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fetch_pc_unit dut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .jmp(jmp), .call(call), .ret(ret),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .tgt(tgt),
    .fetch_addr(fetch_addr), .sp(sp), .tos(tos), .ovf(ovf), .unf(unf)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Apply strobes for one edge (driven at negedge, sampled at next negedge)
  task automatic step(input logic a, j, c, r, h, l, input logic [20:0] t);
    adv = a; jmp = j; call = c; ret = r; irq_hi = h; irq_lo = l; tgt = t;
    @(negedge clk);
    adv = 0; jmp = 0; call = 0; ret = 0; irq_hi = 0; irq_lo = 0; tgt = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2", "pc in reset", 32'(fetch_addr), 0);
    chk("R2", "sp in reset", 32'(sp), 0);
    chk("R2", "tos in reset", 32'(tos), 0);
    chk("R2", "flags in reset", {30'd0, ovf, unf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_seq_jump();
    do_reset();
    step(1,0,0,0,0,0,'0);
    chk("R3", "step 1", 32'(fetch_addr), 32'h2);
    step(0,0,0,0,0,0,'0);
    chk("R3", "hold", 32'(fetch_addr), 32'h2);
    step(0,1,0,0,0,0,21'h12345);
    chk("R1", "odd target bit0 dropped", 32'(fetch_addr), 32'h12344);
    chk("R4", "jump keeps sp", 32'(sp), 0);
    step(0,1,0,0,0,0,21'h1FFFFE);
    step(1,0,0,0,0,0,'0);
    chk("R3", "wrap at top", 32'(fetch_addr), 0);
  endtask

  task automatic t_call_ret();
    do_reset();
    step(1,0,0,0,0,0,'0);
    step(1,0,0,0,0,0,'0);
    step(0,0,1,0,0,0,21'h1234);
    chk("R5", "call target", 32'(fetch_addr), 32'h1234);
    chk("R5", "call sp", 32'(sp), 1);
    chk("R5", "call pushed", 32'(tos), 32'h6);
    step(0,1,0,0,0,0,21'h0A00);
    chk("R4", "jump keeps tos", 32'(tos), 32'h6);
    step(0,0,0,1,0,0,'0);
    chk("R6", "return addr", 32'(fetch_addr), 32'h6);
    chk("R6", "return sp", 32'(sp), 0);
  endtask

  task automatic t_irq();
    do_reset();
    step(1,0,0,0,0,0,'0);
    step(0,0,0,0,0,1,'0);
    chk("R8", "low vector", 32'(fetch_addr), 32'h18);
    chk("R8", "low pushed", 32'(tos), 32'h4);
    step(0,0,0,1,0,0,'0);
    chk("R6", "back from low", 32'(fetch_addr), 32'h4);
    step(0,0,0,0,1,1,'0);
    chk("R8", "both -> high vector", 32'(fetch_addr), 32'h8);
    chk("R8", "single push", 32'(sp), 1);
    chk("R7", "high pushed", 32'(tos), 32'h6);
    step(0,0,0,0,1,0,'0);
    chk("R7", "high vector", 32'(fetch_addr), 32'h8);
    chk("R7", "nested pushed", 32'(tos), 32'hA);
  endtask

  task automatic t_priority();
    do_reset();
    step(0,0,1,0,0,0,21'h100);
    step(1,1,1,1,0,0,21'h700);
    chk("R9", "ret beats call/jmp/adv", 32'(fetch_addr), 32'h2);
    chk("R9", "ret sp", 32'(sp), 0);
    step(1,1,1,0,0,0,21'h300);
    chk("R9", "call beats jmp/adv", 32'(fetch_addr), 32'h300);
    chk("R9", "call pushed", 32'(tos), 32'h4);
    step(1,1,0,0,0,0,21'h500);
    chk("R9", "jmp beats adv", 32'(fetch_addr), 32'h500);
    step(1,1,1,1,0,1,21'h900);
    chk("R9", "low irq beats ret", 32'(fetch_addr), 32'h18);
    chk("R9", "low irq pushes", 32'(sp), 2);
  endtask

  task automatic t_overflow_underflow();
    do_reset();
    for (int i = 0; i < 31; i++) step(0,0,1,0,0,0,21'(32'h1000 + 4*i));
    chk("R10", "full sp", 32'(sp), 31);
    chk("R10", "no ovf yet", 32'(ovf), 0);
    chk("R10", "top before", 32'(tos), 32'h1076);
    step(0,0,1,0,0,0,21'h2000);
    chk("R10", "ovf set", 32'(ovf), 1);
    chk("R10", "sp held", 32'(sp), 31);
    chk("R10", "top kept", 32'(tos), 32'h1076);
    chk("R10", "pc still moves", 32'(fetch_addr), 32'h2000);
    step(0,0,0,1,0,0,'0);
    chk("R6", "lifo 1st", 32'(fetch_addr), 32'h1076);
    chk("R6", "lifo next top", 32'(tos), 32'h1072);
    for (int i = 0; i < 30; i++) step(0,0,0,1,0,0,'0);
    chk("R6", "lifo last", 32'(fetch_addr), 32'h2);
    chk("R6", "drained", 32'(sp), 0);
    chk("R12", "ovf sticky", 32'(ovf), 1);
    step(0,0,0,1,0,0,'0);
    chk("R11", "unf set", 32'(unf), 1);
    chk("R11", "pc zero", 32'(fetch_addr), 0);
    chk("R11", "sp stays 0", 32'(sp), 0);
    step(0,0,1,0,0,0,21'h40);
    chk("R12", "unf sticky", 32'(unf), 1);
    do_reset();
  endtask

  initial begin
    @(negedge clk);
    t_seq_jump();
    t_call_ret();
    t_irq();
    t_priority();
    t_overflow_underflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule